// File: doc/BRIEF.md
# Byte-Serial Port with Sticky Status Flags

This block is an 8-bit synchronous serial port behind a small register interface. Software sets the port up through a control register. It reads the port's state through a status register. It moves bytes through a data register. As master, the port makes the serial clock from the system clock. As slave, it follows a serial clock from outside, and a low-active select input enables it.

Receive and transmit are buffered differently. A completed incoming byte goes from the shift register into a separate read buffer, so software reads a stable value while the next byte shifts in. A written byte goes straight into the shift register and has no holding stage.

Three sticky flags report events: a completed transfer, a write that arrives while a transfer is running, and a select input pulled low while the port is master. Each flag clears only when software performs two steps. First it reads the status register while the flag is set. Then it performs the access that belongs to that flag. A completed byte that would land while the completion flag is still set is dropped and reported on a one-cycle pulse output.

Top module: `spi_port`

## Requirements
- R1: After reset the control, status and data registers all read 0x00 and the serial clock output is low.
- R2: Register offsets are 0 for control, 1 for status and 2 for data. Control bit 6 enables the port and bit 4 selects master. Control bits 1:0 set the serial clock period to 2, 4, 16 or 32 system clocks for codes 0 to 3. A data write starts a transfer only when enable and master are both set. The transfer sends the most significant bit first. The serial clock idles low. Data is sampled on the rising serial clock edge and changes on the falling edge.
- R3: In the status register, bit 7 is the completion flag, bit 6 is the collision flag and bit 4 is the mode-fault flag. Bits 5 and 3:0 always read 0.
- R4: With master cleared, a data write only preloads the outgoing byte. It produces no serial clock and sets no flag.
- R5: When the eighth bit finishes, the completion flag sets, in master mode and in slave mode alike. A data read then returns the received byte.
- R6: A data write during a running transfer sets the collision flag. The byte being shifted is left unchanged.
- R7: The completion flag clears only when a status read that sees it set is followed by a data read or a data write. A data access without that earlier status read leaves the flag set.
- R8: The collision flag clears by the same sequence as in R7.
- R9: If a byte completes while the completion flag is already set, the read buffer keeps its earlier byte and `ovr_o` pulses for one cycle.
- R10: In master mode with enable set, `ss_n` held low sets the mode-fault flag within three clock cycles, clears enable and master, and stops any transfer.
- R11: The mode-fault flag clears only when a status read that sees it set is followed by a control write. Data accesses do not clear it.
- R12: While a transfer is running, a data read returns the previously received byte, not the contents of the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out, most significant bit first |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave select, active low; a mode-fault source in master mode |
| ovr_o | output | 1 | One-cycle pulse when a completed byte is dropped |

## Verification
Assertions check a fixed set of properties on every cycle. The unused status bits read zero, and a slave never drives the serial clock, which idles low when no transfer runs. Each completion sets the flag, and an overrun leaves the read buffer unchanged. A collision leaves the shift register unchanged. A fault forces the port out of master mode. The bench scenarios alone can show the two-step flag clearing, because that depends on the order of accesses. They also cover the divided clock period, the bit order on both data lines and the slave transfer driven from outside. A behavioural model predicts the status byte and the serial clock level on every cycle of the master scenarios.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck_o,
  input  logic          sck_i,
  output logic          sdo,
  input  logic          sdi,
  input  logic          ss_n,
  output logic          ovr_o
);
  localparam int CW = $clog2(DW);

  logic en, mst;
  logic [1:0] rate;
  logic spif, wcol, modf, spif_arm, wcol_arm, modf_arm;
  logic [DW-1:0] sh, rxb;
  logic busy, sck_r, samp;
  logic [CW-1:0] bits;
  logic [3:0] div, lim;
  logic [2:0] sck_sy;
  logic [1:0] ss_sy;
  logic wr_d, rd_d, acc_d, rd_s, wr_c, ss_low, sl, tick, rise, fall, done, fault, start, collide;
  logic [DW-1:0] ctrl_v, stat_v;

  assign wr_d    = bus_wr & (bus_addr == 2'd2);
  assign rd_d    = bus_rd & (bus_addr == 2'd2);
  assign acc_d   = wr_d | rd_d;
  assign rd_s    = bus_rd & (bus_addr == 2'd1);
  assign wr_c    = bus_wr & (bus_addr == 2'd0);
  assign ss_low  = ~ss_sy[1];
  assign sl      = en & ~mst & ss_low;
  assign tick    = busy & mst & (div == lim);
  assign rise    = mst ? (tick & ~sck_r) : (sl & sck_sy[1] & ~sck_sy[2]);
  assign fall    = mst ? (tick & sck_r) : (sl & busy & ~sck_sy[1] & sck_sy[2]);
  assign done    = fall & (bits == CW'(DW - 1));
  assign fault   = en & mst & ss_low;
  assign start   = wr_d & en & mst & ~busy;
  assign collide = wr_d & busy;
  assign sck_o   = sck_r;
  assign sdo     = sh[DW-1];

  always_comb begin
    case (rate)
      2'd0:    lim = 4'd0;
      2'd1:    lim = 4'd1;
      2'd2:    lim = 4'd7;
      default: lim = 4'd15;
    endcase
    ctrl_v = '0;
    ctrl_v[6] = en;
    ctrl_v[4] = mst;
    ctrl_v[1:0] = rate;
    stat_v = '0;
    stat_v[7] = spif;
    stat_v[6] = wcol;
    stat_v[4] = modf;
    case (bus_addr)
      2'd0:    bus_rdata = ctrl_v;
      2'd1:    bus_rdata = stat_v;
      2'd2:    bus_rdata = rxb;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mst <= 1'b0; rate <= 2'd0;
      spif <= 1'b0; wcol <= 1'b0; modf <= 1'b0;
      spif_arm <= 1'b0; wcol_arm <= 1'b0; modf_arm <= 1'b0;
      sh <= '0; rxb <= '0; busy <= 1'b0; sck_r <= 1'b0; samp <= 1'b0;
      bits <= '0; div <= '0; sck_sy <= '0; ss_sy <= 2'b11; ovr_o <= 1'b0;
    end else begin
      ss_sy  <= {ss_sy[0], ss_n};
      sck_sy <= {sck_sy[1:0], sck_i};
      ovr_o  <= 1'b0;
      if (rd_s) begin
        if (spif) spif_arm <= 1'b1;
        if (wcol) wcol_arm <= 1'b1;
        if (modf) modf_arm <= 1'b1;
      end
      if (acc_d && spif_arm) begin spif <= 1'b0; spif_arm <= 1'b0; end
      if (acc_d && wcol_arm) begin wcol <= 1'b0; wcol_arm <= 1'b0; end
      if (wr_c && modf_arm) begin modf <= 1'b0; modf_arm <= 1'b0; end
      if (collide) wcol <= 1'b1;
      if (busy && mst) begin
        div <= tick ? '0 : div + 4'd1;
        if (tick) sck_r <= ~sck_r;
      end
      if (rise) begin samp <= sdi; busy <= 1'b1; end
      if (fall) begin sh <= {sh[DW-2:0], samp}; bits <= bits + 1'b1; end
      if (done) begin
        busy <= 1'b0;
        bits <= '0;
        spif <= 1'b1;
        if (spif) ovr_o <= 1'b1;
        else rxb <= {sh[DW-2:0], samp};
      end
      if (start) begin
        sh <= bus_wdata; busy <= 1'b1; bits <= '0; div <= '0; sck_r <= 1'b0;
      end else if (wr_d && !busy && !mst) begin
        sh <= bus_wdata;
      end
      if (!mst && !ss_low) begin busy <= 1'b0; bits <= '0; end
      if (wr_c) begin
        en <= bus_wdata[6]; mst <= bus_wdata[4]; rate <= bus_wdata[1:0];
        busy <= 1'b0; bits <= '0; div <= '0; sck_r <= 1'b0;
      end
      if (fault) begin
        en <= 1'b0; mst <= 1'b0; busy <= 1'b0; bits <= '0; div <= '0; sck_r <= 1'b0;
        modf <= 1'b1;
      end
    end
  end
endmodule

module spi_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          mst,
  input logic          en,
  input logic          busy,
  input logic          sck_r,
  input logic          fall,
  input logic          fault,
  input logic          collide,
  input logic          done,
  input logic          spif,
  input logic          modf,
  input logic [DW-1:0] sh,
  input logic [DW-1:0] rxb
);
  p_status_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata[5] == 1'b0 && bus_rdata[3:0] == 4'd0));
  p_slave_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mst |-> !sck_r);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_r);
  p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> spif);
  p_wcol_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !fall && !fault) |=> (sh == $past(sh)));
  p_ovr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && spif) |=> (rxb == $past(rxb)));
  p_fault_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (modf && !en && !mst));
endmodule

bind spi_port spi_port_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_spi_port.sv
module sim_spi_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic sck_o, sdo, ovr_o;
  logic sck_i = 1'b0, ss_n = 1'b1, s_sdi = 1'b0, slave_ph = 1'b0;
  logic [7:0] mb = 8'h00;
  logic [2:0] fcnt;
  logic [7:0] cap, s_cap;
  logic sdi;
  logic cmp_en = 1'b0;
  int errors = 0, checks = 0, ovr_seen = 0;

  always #4 clk = ~clk;

  assign sdi = slave_ph ? s_sdi : mb[3'd7 - fcnt];

  spi_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(rd), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .sck_o(sck_o), .sck_i(sck_i),
    .sdo(sdo), .sdi(sdi), .ss_n(ss_n), .ovr_o(ovr_o)
  );

  always @(negedge sck_o or negedge rst_n)
    if (!rst_n) fcnt <= 3'd0; else fcnt <= fcnt + 3'd1;
  always @(posedge sck_o or negedge rst_n)
    if (!rst_n) cap <= 8'd0; else cap <= {cap[6:0], sdo};
  always @(posedge sck_i or negedge rst_n)
    if (!rst_n) s_cap <= 8'd0; else s_cap <= {s_cap[6:0], sdo};
  always @(posedge clk) if (ovr_o) ovr_seen = ovr_seen + 1;

  bit m_spif, m_wcol, m_modf, a_s, a_w, a_m, m_en, m_mst, q1, q2;
  int m_half, m_cnt;
  logic [7:0] m_rx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_spif = 0; m_wcol = 0; m_modf = 0; a_s = 0; a_w = 0; a_m = 0;
      m_en = 0; m_mst = 0; q1 = 1; q2 = 1; m_half = 1; m_cnt = 0; m_rx = 8'd0;
    end else begin
      int old;
      bit sp, flt;
      old = m_cnt; sp = m_spif;
      flt = m_en && m_mst && !q2;
      q2 = q1; q1 = ss_n;
      if (old > 0) m_cnt = old - 1;
      if (rd && addr == 2'd1) begin
        if (m_spif) a_s = 1;
        if (m_wcol) a_w = 1;
        if (m_modf) a_m = 1;
      end
      if ((rd || wr) && addr == 2'd2) begin
        if (a_s) begin m_spif = 0; a_s = 0; end
        if (a_w) begin m_wcol = 0; a_w = 0; end
      end
      if (wr && addr == 2'd0 && a_m) begin m_modf = 0; a_m = 0; end
      if (wr && addr == 2'd2) begin
        if (old > 0) m_wcol = 1;
        else if (m_en && m_mst) m_cnt = 16 * m_half;
      end
      if (old == 1) begin
        if (!sp) m_rx = mb;
        m_spif = 1;
      end
      if (wr && addr == 2'd0) begin
        m_en = wdata[6]; m_mst = wdata[4]; m_cnt = 0;
        case (wdata[1:0]) 2'd0: m_half = 1; 2'd1: m_half = 2; 2'd2: m_half = 8; default: m_half = 16; endcase
      end
      if (flt) begin m_en = 0; m_mst = 0; m_cnt = 0; m_modf = 1; end
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_en && rst_n && !rd && !wr && addr == 2'd1) begin
      check("R3 R7 R8 R11 model status", rdata == {m_spif, m_wcol, 1'b0, m_modf, 4'b0},
            rdata, {m_spif, m_wcol, 1'b0, m_modf, 4'b0});
      if (m_cnt == 0) check("R2 model idle clock", sck_o == 1'b0, sck_o, 0);
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 2'd1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; addr = 2'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_sim();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    logic [7:0] d;
    realtime t0;
    int ov0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    check("R1 status after reset", rdata == 8'h00, rdata, 0);
    check("R1 sck low after reset", sck_o == 1'b0, sck_o, 0);
    bus_read(2'd0, d); check("R1 control after reset", d == 8'h00, d, 0);
    bus_read(2'd2, d); check("R1 data after reset", d == 8'h00, d, 0);
    cmp_en = 1'b1;

    bus_write(2'd0, 8'h50);
    mb = 8'h3C;
    bus_write(2'd2, 8'hA5);
    idle(24);
    check("R2 msb-first transmit", cap == 8'hA5, cap, 8'hA5);
    check("R5 completion flag master", rdata == 8'h80, rdata, 8'h80);
    bus_read(2'd2, d); check("R5 received byte", d == 8'h3C, d, 8'h3C);
    idle(1);
    check("R7 data access without status read keeps flag", rdata == 8'h80, rdata, 8'h80);
    bus_read(2'd1, d);
    bus_read(2'd2, d);
    idle(1);
    check("R7 two-step clear", rdata == 8'h00, rdata, 0);

    bus_write(2'd0, 8'h53);
    mb = 8'hC3;
    bus_write(2'd2, 8'h5A);
    @(posedge sck_o); t0 = $realtime;
    @(posedge sck_o);
    check("R2 divide by 32 period", ($realtime - t0) == 256.0, int'($realtime - t0), 256);
    bus_read(2'd2, d); check("R12 buffer during transfer", d == 8'h3C, d, 8'h3C);
    bus_write(2'd2, 8'hFF);
    idle(1);
    check("R6 collision flag", rdata == 8'h40, rdata, 8'h40);
    idle(260);
    check("R6 byte unaffected by collision", cap == 8'h5A, cap, 8'h5A);
    check("R6 both flags set", rdata == 8'hC0, rdata, 8'hC0);
    bus_read(2'd1, d);
    bus_read(2'd2, d); check("R5 second received byte", d == 8'hC3, d, 8'hC3);
    idle(1);
    check("R8 collision cleared with completion", rdata == 8'h00, rdata, 0);

    bus_write(2'd0, 8'h50);
    mb = 8'h11;
    bus_write(2'd2, 8'h22);
    idle(20);
    ov0 = ovr_seen;
    mb = 8'h99;
    bus_write(2'd2, 8'h33);
    idle(20);
    bus_read(2'd2, d); check("R9 overrun keeps earlier byte", d == 8'h11, d, 8'h11);
    check("R9 overrun pulse", ovr_seen == ov0 + 1, ovr_seen - ov0, 1);
    bus_read(2'd1, d);
    bus_read(2'd2, d);

    bus_write(2'd0, 8'h40);
    bus_write(2'd2, 8'h77);
    idle(40);
    check("R4 slave write no start", rdata == 8'h00 && sck_o == 1'b0, rdata, 0);

    bus_write(2'd0, 8'h50);
    @(negedge clk); ss_n = 1'b0;
    idle(4);
    check("R10 mode fault set", rdata == 8'h10, rdata, 8'h10);
    bus_read(2'd0, d); check("R10 enable and master cleared", d == 8'h00, d, 0);
    ss_n = 1'b1;
    bus_write(2'd2, 8'h12);
    idle(30);
    check("R10 no transfer after fault", sck_o == 1'b0 && rdata == 8'h10, rdata, 8'h10);
    bus_read(2'd1, d);
    bus_read(2'd2, d);
    idle(1);
    check("R11 data access does not clear fault", rdata == 8'h10, rdata, 8'h10);
    bus_write(2'd0, 8'h50);
    idle(1);
    check("R11 control write clears fault", rdata == 8'h00, rdata, 0);

    cmp_en = 1'b0;
    bus_write(2'd0, 8'h40);
    bus_write(2'd2, 8'h77);
    slave_ph = 1'b1;
    d = 8'hB4;
    s_sdi = d[7];
    @(negedge clk); ss_n = 1'b0;
    idle(4);
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b1; idle(6);
      sck_i = 1'b0; if (i < 7) s_sdi = d[6 - i]; idle(6);
    end
    idle(6);
    check("R5 completion flag slave", rdata == 8'h80, rdata, 8'h80);
    check("R5 slave transmit", s_cap == 8'h77, s_cap, 8'h77);
    bus_read(2'd2, d); check("R5 slave receive", d == 8'hB4, d, 8'hB4);
    ss_n = 1'b1;
    idle(4);
    finish_sim();
  end
endmodule